// File: doc/BRIEF.md
# Column-Foot Sparse Hit Word Builder

This block sits below a vertical chain of pixel-group controllers. On a start pulse it launches a readout token into the chain. The controllers then report their stored hits one at a time, in token order. Each report carries a group number, a local pixel row inside the group, a side bit that picks one of the two pixel columns served by a double-sided controller, and a 16-bit timestamp.

The block turns each report into absolute row and column addresses and packs them with the timestamp into one 38-bit word. Only real hits produce words. Nothing is compressed or dropped.

The words leave through a two-stage register pipeline with a valid/ready handshake. With the consumer always ready, it takes one report per clock. When the consumer stalls, back-pressure reaches the chain and no word is lost or repeated. The readout ends when the token comes back from the last controller. A one-cycle done pulse marks that event.

Top module: `colbase_hit_asm`

## Requirements
- R1: Each output word places the row address in bits [37:27], the column address in bits [26:16] and the timestamp in bits [15:0].
- R2: The row address equals the group number times GROUP_ROWS (12 by default) plus the local row. Rows 0 through 1199 are reachable.
- R3: The column address equals the COL_BASE parameter plus the side bit (0 or 1).
- R4: While idle, a start pulse raises `tok_inject_o` for exactly one cycle, in the cycle after start is sampled. `busy_o` goes high in that same cycle.
- R5: A start pulse during a readout produces no further token pulse and leaves `busy_o` high.
- R6: A token return sampled during a readout raises `done_o` for exactly one cycle, in the next cycle, and `busy_o` drops in that cycle. A token return while idle raises no done pulse.
- R7: While idle, `hit_ready_o` is low and no report is taken, so no word appears.
- R8: Words leave in the order their reports were accepted, with none lost or duplicated. While `word_valid_o` is high and `word_ready_i` is low, the word and its valid stay unchanged.
- R9: With `word_ready_i` held high, a report is taken on every clock. Its word is valid two cycles after the accepting edge.
- R10: After reset, `word_valid_o`, `tok_inject_o`, `done_o`, `busy_o` and `hit_ready_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begins a readout when idle |
| tok_inject_o | output | 1 | One-cycle token launch into the chain |
| tok_return_i | input | 1 | Token arriving back from the last controller |
| hit_valid_i | input | 1 | A controller presents a hit report |
| hit_ready_o | output | 1 | Report accepted on this edge when valid is also high |
| hit_grp_i | input | 7 | Group number within the column |
| hit_loc_i | input | 4 | Local row inside the group |
| hit_side_i | input | 1 | Which of the two served pixel columns |
| hit_ts_i | input | 16 | Hit timestamp |
| word_valid_o | output | 1 | Output word present |
| word_ready_i | input | 1 | Consumer takes the word on this edge |
| word_data_o | output | 38 | Packed row, column and timestamp word |
| busy_o | output | 1 | Readout in progress |
| done_o | output | 1 | One-cycle end-of-readout pulse |

## Verification
The bench drives reports both back-to-back and under an irregular stall pattern, and checks that every word matches its report in order. A pipeline that overwrote a held stage would lose a word, and one that reloaded it would repeat a word. Both errors show up as an order or count mismatch. The vectors hit the row extremes 0 and 1199, both side values, and timestamps with all bits set or cleared, so a wrong multiply, a wrong field offset or a truncated field gives a wrong word. Directed tests cover a start during a readout, which would re-launch a token in a faulty design, and a token return while idle, which would raise a spurious done. They also fill the pipeline under a full stall to show that `hit_ready_o` drops and the held word does not move.

// File: rtl/colbase_pkg.sv
package colbase_pkg;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;

    typedef struct packed {
        seq_state_e state;
        logic       inject;
        logic       done;
    } seq_regs_t;

endpackage

// File: rtl/colbase_seq.sv
module colbase_seq
    import colbase_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic start_i,
    input  logic tok_return_i,
    output logic tok_inject_o,
    output logic busy_o,
    output logic done_o
);

    seq_regs_t seq_d, seq_q;

    always_comb begin
        seq_d        = seq_q;
        seq_d.inject = 1'b0;
        seq_d.done   = 1'b0;
        unique case (seq_q.state)
            SEQ_IDLE: begin
                if (start_i) begin
                    seq_d.state  = SEQ_RUN;
                    seq_d.inject = 1'b1;
                end
            end
            SEQ_RUN: begin
                // start is deliberately not looked at here
                if (tok_return_i) begin
                    seq_d.state = SEQ_IDLE;
                    seq_d.done  = 1'b1;
                end
            end
            default: seq_d.state = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            seq_q <= '{state: SEQ_IDLE, inject: 1'b0, done: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign tok_inject_o = seq_q.inject;
    assign done_o       = seq_q.done;
    assign busy_o       = (seq_q.state == SEQ_RUN);

endmodule

// File: rtl/colbase_addr_map.sv
module colbase_addr_map #(
    parameter int GRP_W      = 7,
    parameter int LOC_W      = 4,
    parameter int ROW_W      = 11,
    parameter int COL_W      = 11,
    parameter int TS_W       = 16,
    parameter int GROUP_ROWS = 12,
    parameter int COL_BASE   = 0,
    localparam int WORD_W    = ROW_W + COL_W + TS_W
) (
    input  logic [GRP_W-1:0]  grp_i,
    input  logic [LOC_W-1:0]  loc_i,
    input  logic              side_i,
    input  logic [TS_W-1:0]   ts_i,
    output logic [WORD_W-1:0] word_o
);

    localparam logic [ROW_W-1:0] ROWS_PER_GRP = ROW_W'(GROUP_ROWS);
    localparam logic [COL_W-1:0] COL_ORIGIN   = COL_W'(COL_BASE);

    logic [ROW_W-1:0] row_abs;
    logic [COL_W-1:0] col_abs;

    always_comb begin
        row_abs = ROW_W'(ROW_W'(grp_i) * ROWS_PER_GRP) + ROW_W'(loc_i);
        col_abs = COL_ORIGIN + COL_W'(side_i);
        // row on top, column in the middle, timestamp at the bottom
        word_o  = {row_abs, col_abs, ts_i};
    end

endmodule

// File: rtl/colbase_word_pipe.sv
module colbase_word_pipe #(
    parameter int W      = 38,
    parameter int STAGES = 2
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         in_valid_i,
    output logic         in_ready_o,
    input  logic [W-1:0] in_data_i,
    output logic         out_valid_o,
    input  logic         out_ready_i,
    output logic [W-1:0] out_data_o
);

    typedef struct packed {
        logic [STAGES-1:0]        vld;
        logic [STAGES-1:0][W-1:0] dat;
    } pipe_regs_t;

    pipe_regs_t pipe_d, pipe_q;
    logic [STAGES:0] adv;

    // a stage may load when it is empty or when its own content moves on
    assign adv[STAGES] = out_ready_i;
    for (genvar g = 0; g < STAGES; g++) begin : g_adv
        assign adv[g] = !pipe_q.vld[g] || adv[g+1];
    end

    always_comb begin
        pipe_d = pipe_q;
        if (adv[0]) begin
            pipe_d.vld[0] = in_valid_i;
            pipe_d.dat[0] = in_data_i;
        end
        for (int s = 1; s < STAGES; s++) begin
            if (adv[s]) begin
                pipe_d.vld[s] = pipe_q.vld[s-1];
                pipe_d.dat[s] = pipe_q.dat[s-1];
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign in_ready_o  = adv[0];
    assign out_valid_o = pipe_q.vld[STAGES-1];
    assign out_data_o  = pipe_q.dat[STAGES-1];

endmodule

// File: rtl/colbase_hit_asm.sv
module colbase_hit_asm #(
    parameter int GRP_W       = 7,
    parameter int LOC_W       = 4,
    parameter int ROW_W       = 11,
    parameter int COL_W       = 11,
    parameter int TS_W        = 16,
    parameter int GROUP_ROWS  = 12,
    parameter int COL_BASE    = 0,
    parameter int PIPE_STAGES = 2,
    localparam int WORD_W     = ROW_W + COL_W + TS_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    output logic              tok_inject_o,
    input  logic              tok_return_i,
    input  logic              hit_valid_i,
    output logic              hit_ready_o,
    input  logic [GRP_W-1:0]  hit_grp_i,
    input  logic [LOC_W-1:0]  hit_loc_i,
    input  logic              hit_side_i,
    input  logic [TS_W-1:0]   hit_ts_i,
    output logic              word_valid_o,
    input  logic              word_ready_i,
    output logic [WORD_W-1:0] word_data_o,
    output logic              busy_o,
    output logic              done_o
);

    logic              run;
    logic              pipe_in_ready;
    logic [WORD_W-1:0] mapped_word;

    colbase_seq u_seq (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .start_i      (start_i),
        .tok_return_i (tok_return_i),
        .tok_inject_o (tok_inject_o),
        .busy_o       (run),
        .done_o       (done_o)
    );

    colbase_addr_map #(
        .GRP_W      (GRP_W),
        .LOC_W      (LOC_W),
        .ROW_W      (ROW_W),
        .COL_W      (COL_W),
        .TS_W       (TS_W),
        .GROUP_ROWS (GROUP_ROWS),
        .COL_BASE   (COL_BASE)
    ) u_map (
        .grp_i  (hit_grp_i),
        .loc_i  (hit_loc_i),
        .side_i (hit_side_i),
        .ts_i   (hit_ts_i),
        .word_o (mapped_word)
    );

    colbase_word_pipe #(
        .W      (WORD_W),
        .STAGES (PIPE_STAGES)
    ) u_pipe (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .in_valid_i  (hit_valid_i && run),
        .in_ready_o  (pipe_in_ready),
        .in_data_i   (mapped_word),
        .out_valid_o (word_valid_o),
        .out_ready_i (word_ready_i),
        .out_data_o  (word_data_o)
    );

    assign hit_ready_o = run && pipe_in_ready;
    assign busy_o      = run;

endmodule

// File: rtl/colbase_hit_asm_chk.sv
module colbase_hit_asm_chk #(
    parameter int WORD_W = 38
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              start_i,
    input logic              tok_inject_o,
    input logic              tok_return_i,
    input logic              hit_ready_o,
    input logic              word_valid_o,
    input logic              word_ready_i,
    input logic [WORD_W-1:0] word_data_o,
    input logic              busy_o,
    input logic              done_o
);

    p_hold_word_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (word_valid_o && !word_ready_i) |=> (word_valid_o && $stable(word_data_o)));

    p_inject_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tok_inject_o |=> !tok_inject_o);

    p_start_launch_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!busy_o && start_i) |=> (tok_inject_o && busy_o));

    p_start_ignored_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && start_i && !tok_return_i) |=> (!tok_inject_o && busy_o));

    p_return_done_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && tok_return_i) |=> (done_o && !busy_o));

    p_done_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    p_idle_no_take_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy_o |-> !hit_ready_o);

endmodule

bind colbase_hit_asm colbase_hit_asm_chk #(
    .WORD_W (ROW_W + COL_W + TS_W)
) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .tok_inject_o (tok_inject_o),
    .tok_return_i (tok_return_i),
    .hit_ready_o  (hit_ready_o),
    .word_valid_o (word_valid_o),
    .word_ready_i (word_ready_i),
    .word_data_o  (word_data_o),
    .busy_o       (busy_o),
    .done_o       (done_o)
);

// File: tb/colbase_hit_asm_tb_top.sv
`timescale 1ns/1ps
module colbase_hit_asm_tb_top;

    localparam int COLB   = 640;
    localparam int NVEC   = 10;
    localparam int VW     = 7 + 4 + 1 + 16;
    // {group, local row, side, timestamp}
    localparam logic [VW-1:0] VEC [NVEC] = '{
        {7'd0,  4'd0,  1'b0, 16'h0000},
        {7'd99, 4'd11, 1'b1, 16'hFFFF},
        {7'd1,  4'd0,  1'b0, 16'h1234},
        {7'd0,  4'd11, 1'b1, 16'h8001},
        {7'd50, 4'd5,  1'b0, 16'hAAAA},
        {7'd7,  4'd3,  1'b1, 16'h5555},
        {7'd98, 4'd6,  1'b0, 16'h0001},
        {7'd25, 4'd9,  1'b1, 16'h7FFF},
        {7'd63, 4'd2,  1'b0, 16'hC3C3},
        {7'd10, 4'd10, 1'b1, 16'h0F0F}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        tok_inj;
    logic        tok_ret = 1'b0;
    logic        hv = 1'b0;
    logic        hr;
    logic [6:0]  hgrp = '0;
    logic [3:0]  hloc = '0;
    logic        hside = 1'b0;
    logic [15:0] hts = '0;
    logic        wv;
    logic        wr = 1'b1;
    logic [37:0] wd;
    logic        busy;
    logic        done;

    int checks = 0;
    int errors = 0;
    int rmode  = 0;
    int cyc    = 0;
    int stalls = 0;
    int qw = 0;
    int qr = 0;
    logic [37:0] expq [64];
    bit finished = 1'b0;

    always #4 clk = ~clk;

    colbase_hit_asm #(.COL_BASE(COLB)) dut_i (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .start_i      (start),
        .tok_inject_o (tok_inj),
        .tok_return_i (tok_ret),
        .hit_valid_i  (hv),
        .hit_ready_o  (hr),
        .hit_grp_i    (hgrp),
        .hit_loc_i    (hloc),
        .hit_side_i   (hside),
        .hit_ts_i     (hts),
        .word_valid_o (wv),
        .word_ready_i (wr),
        .word_data_o  (wd),
        .busy_o       (busy),
        .done_o       (done)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // R1 R2 R3: expected word computed from the report fields
    function automatic logic [37:0] model(input logic [6:0] g, input logic [3:0] l,
                                          input logic s, input logic [15:0] t);
        int row;
        int col;
        row = int'(g) * 12 + int'(l);
        col = COLB + int'(s);
        return {row[10:0], col[10:0], t};
    endfunction

    // consumer ready pattern
    initial begin
        forever begin
            @(posedge clk);
            #1;
            cyc++;
            case (rmode)
                0: wr = 1'b1;
                1: wr = ((cyc % 3) != 0) && ((cyc % 7) != 2);
                default: wr = 1'b0;
            endcase
        end
    end

    // scoreboard, sampled mid-cycle
    always @(negedge clk) begin
        if (rst_n) begin
            if (hv && hr) begin
                expq[qw % 64] = model(hgrp, hloc, hside, hts);
                qw++;
            end
            if (hv && !hr && rmode == 0 && busy) stalls++;
            if (wv && wr) begin
                if (qr < qw) begin
                    chk(wd == expq[qr % 64], "R1/R2/R3/R8 word", 64'(wd), 64'(expq[qr % 64]));
                end else begin
                    chk(1'b0, "R8 extra word", 64'(wd), 64'(0));
                end
                qr++;
            end
        end
    end

    task automatic put(input int i);
        {hgrp, hloc, hside, hts} = VEC[i];
        hv = 1'b1;
        do @(negedge clk); while (!hr);
        @(posedge clk);
        #1;
    endtask

    task automatic drain();
        hv = 1'b0;
        repeat (12) @(posedge clk);
        #1;
    endtask

    task automatic do_start();
        start = 1'b1;
        @(posedge clk);
        #1;
        start = 1'b0;
    endtask

    task automatic do_return();
        tok_ret = 1'b1;
        @(posedge clk);
        #1;
        tok_ret = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R10 reset state
        @(negedge clk);
        chk({wv, tok_inj, done, busy, hr} == 5'b0, "R10 reset outputs", 64'({wv, tok_inj, done, busy, hr}), 64'(0));
        @(posedge clk);
        #1;
        rst_n = 1'b1;

        // R7: idle, a presented report is refused
        {hgrp, hloc, hside, hts} = VEC[4];
        hv = 1'b1;
        repeat (4) begin
            @(negedge clk);
            chk(hr == 1'b0, "R7 idle ready", 64'(hr), 64'(0));
        end
        hv = 1'b0;
        @(negedge clk);
        chk(wv == 1'b0 && qw == 0, "R7 idle no word", 64'(wv), 64'(0));

        // R6: token return while idle gives no done
        @(posedge clk);
        #1;
        do_return();
        @(negedge clk);
        chk(done == 1'b0, "R6 idle return", 64'(done), 64'(0));

        // R4: start launches a single token pulse
        @(posedge clk);
        #1;
        do_start();
        @(negedge clk);
        chk(tok_inj == 1'b1 && busy == 1'b1, "R4 inject", 64'({tok_inj, busy}), 64'(3));
        @(negedge clk);
        chk(tok_inj == 1'b0, "R4 single pulse", 64'(tok_inj), 64'(0));

        // R5: start during readout ignored
        @(posedge clk);
        #1;
        do_start();
        @(negedge clk);
        chk(tok_inj == 1'b0 && busy == 1'b1, "R5 restart ignored", 64'({tok_inj, busy}), 64'(1));

        // R9 latency: single report into an empty pipe
        @(posedge clk);
        #1;
        put(2);
        hv = 1'b0;
        @(negedge clk);
        chk(wv == 1'b0, "R9 latency early", 64'(wv), 64'(0));
        @(negedge clk);
        chk(wv == 1'b1, "R9 latency two", 64'(wv), 64'(1));
        drain();

        // table walk, back to back with consumer ready (R1 R2 R3 R9)
        stalls = 0;
        for (int i = 0; i < NVEC; i++) put(i);
        hv = 1'b0;
        chk(stalls == 0, "R9 full rate", 64'(stalls), 64'(0));
        drain();

        // R8: full stall fills the pipe, then holds
        rmode = 2;
        @(posedge clk);
        #1;
        put(5);
        put(6);
        {hgrp, hloc, hside, hts} = VEC[7];
        hv = 1'b1;
        @(negedge clk);
        chk(hr == 1'b0, "R8 full backpressure", 64'(hr), 64'(0));
        begin
            logic [37:0] held;
            held = wd;
            repeat (3) @(negedge clk);
            chk(wv == 1'b1 && wd == held, "R8 held word", 64'(wd), 64'(held));
        end
        rmode = 0;
        do @(negedge clk); while (!hr);
        @(posedge clk);
        #1;
        hv = 1'b0;
        drain();

        // R8: irregular stalls with the table again
        rmode = 1;
        for (int i = NVEC - 1; i >= 0; i--) put(i);
        hv = 1'b0;
        rmode = 0;
        drain();
        chk(qr == qw, "R8 count", 64'(qr), 64'(qw));
        chk(wv == 1'b0, "R8 empty after drain", 64'(wv), 64'(0));

        // R6: token return ends the readout
        do_return();
        @(negedge clk);
        chk(done == 1'b1 && busy == 1'b0, "R6 done", 64'({done, busy}), 64'(2));
        @(negedge clk);
        chk(done == 1'b0, "R6 done single", 64'(done), 64'(0));
        chk(hr == 1'b0, "R7 after end", 64'(hr), 64'(0));

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule